// File: doc/BRIEF.md
# Text-Mode Character Display Renderer

This block turns a character buffer into a monochrome raster with VGA-style timing. It runs on the pixel clock and keeps horizontal and vertical position counters. For each character cell in the text grid it requests one byte from an external character buffer, looks up the glyph slice for the current scan line in a built-in character generator, and loads that slice into a 9-bit pixel shift register. There is no frame store: every cell is fetched again on every scan line that crosses it.

The default grid is 80 columns by 24 rows of 9x9-pixel cells, so the text occupies 720x216 pixels in the top-left corner of a 720x400 active area. The rest of the active area and all blanking intervals are dark. The upper bit of each character byte shows that cell in reverse video. A cursor, placed by row and column inputs, inverts its whole cell and blinks with a period set in frames. The buffer is read through a plain synchronous port: the address goes out and the data comes back one clock later.

Top module: `txtvga_render`

## Requirements
- R1: While `rst_ni` is low, `vid_o`=0, `hsync_o`=1, `vsync_o`=0 and `mem_addr_o`=0. After release, the outputs lag the internal position counter by three clocks. The raster point (x=0, y=0) is on the outputs after the third rising edge that follows the release, and before that the outputs keep their reset values.
- R2: A line is H_ACTIVE+H_FP+H_SYNC+H_BP clocks long. `hsync_o` is low (active) exactly for x in [H_ACTIVE+H_FP, H_ACTIVE+H_FP+H_SYNC) and high otherwise.
- R3: A frame is V_ACTIVE+V_FP+V_SYNC+V_BP lines long. `vsync_o` is high (active) exactly on lines y in [V_ACTIVE+V_FP, V_ACTIVE+V_FP+V_SYNC) and low otherwise.
- R4: When the counter is at a text-area position (x < COLS*9, y < ROWS*9), `mem_addr_o` = (y/9)*COLS + x/9. The address is held for the nine clocks of that cell and is presented three clocks before the cell's first pixel reaches `vid_o`. Outside the text area `mem_addr_o` is 0.
- R5: For a code c (bits 6:0 of the byte) on cell line r, the glyph slice is 9'b0 when r = 8 and {1'b0, c[6:0] ^ r[6:0], 1'b0} when r < 8. Pixel k of the cell (k = 0 is leftmost) is bit 8-k of that slice.
- R6: When bit 7 of the byte is 1, all nine pixels of that cell on that line are inverted.
- R7: `vid_o` is 0 outside the text area. This covers the active area beyond the grid and all blanking.
- R8: With `cur_en_i` = 1 and the cursor visible, the cell at row `cur_row_i`, column `cur_col_i` is inverted on every line. This inversion XORs with the reverse bit, so the cursor on a reversed cell shows the plain glyph.
- R9: Frames are numbered from 0 at reset release. The cursor is visible in frame f when (f / BLINK_FRAMES) is even and hidden otherwise.
- R10: With `cur_en_i` = 0, the cursor row and column inputs have no effect on `vid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_en_i | input | 1 | Cursor enable |
| cur_row_i | input | $clog2(ROWS) | Cursor row |
| cur_col_i | input | $clog2(COLS) | Cursor column |
| mem_addr_o | output | $clog2(COLS*ROWS) | Character buffer read address |
| mem_data_i | input | 8 | Character byte, valid one clock after its address |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active high |
| vid_o | output | 1 | Monochrome pixel |

## Verification
The hardest case to reach is the cursor during its hidden blink phase and on its return, above all when it sits on a reversed character at the last row and column, where the two inversions cancel. The bench builds the block with a tiny grid, short porches and a two-frame blink period. A few frames then cover both blink phases, and a single reversed byte at the final buffer address meets the cursor. Every output pixel, sync level and address across thirteen frames is compared against a raster model computed from frame, line and cell indices.

// File: rtl/txtvga_render.sv
module txtvga_render #(
  parameter int COLS         = 80,
  parameter int ROWS         = 24,
  parameter int H_ACTIVE     = 720,
  parameter int H_FP         = 18,
  parameter int H_SYNC       = 108,
  parameter int H_BP         = 54,
  parameter int V_ACTIVE     = 400,
  parameter int V_FP         = 12,
  parameter int V_SYNC       = 2,
  parameter int V_BP         = 35,
  parameter int BLINK_FRAMES = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cur_en_i,
  input  logic [$clog2(ROWS)-1:0]        cur_row_i,
  input  logic [$clog2(COLS)-1:0]        cur_col_i,
  output logic [$clog2(COLS*ROWS)-1:0]   mem_addr_o,
  input  logic [7:0]                     mem_data_i,
  output logic                           hsync_o,
  output logic                           vsync_o,
  output logic                           vid_o
);
  localparam int CELL_W  = 9;
  localparam int CELL_H  = 9;
  localparam int GLYPHS  = 128;
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);
  localparam int AW      = $clog2(COLS * ROWS);
  localparam int BW      = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;
  localparam int TXT_W   = COLS * CELL_W;
  localparam int TXT_H   = ROWS * CELL_H;
  localparam int HS_BEG  = H_ACTIVE + H_FP;
  localparam int HS_END  = HS_BEG + H_SYNC;
  localparam int VS_BEG  = V_ACTIVE + V_FP;
  localparam int VS_END  = VS_BEG + V_SYNC;

  function automatic logic [8:0] glyph_row(input int c, input int r);
    logic [6:0] cb;
    cb = 7'(c);
    if (r < CELL_H - 1) return {1'b0, cb ^ 7'(r), 1'b0};
    return 9'd0;
  endfunction

  logic [8:0] rom [GLYPHS*CELL_H];
  for (genvar g = 0; g < GLYPHS * CELL_H; g++) begin : g_rom
    assign rom[g] = glyph_row(g / CELL_H, g % CELL_H);
  end

  // position counters (fetch timeline)
  logic [HW-1:0] hc, col;
  logic [3:0]    hph;
  logic [VW-1:0] vc, row;
  logic [3:0]    vph;
  logic          h_last, v_last;

  assign h_last = int'(hc) == H_TOTAL - 1;
  assign v_last = int'(vc) == V_TOTAL - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc <= '0; col <= '0; hph <= '0;
    end else if (h_last) begin
      hc <= '0; col <= '0; hph <= '0;
    end else begin
      hc <= hc + 1'b1;
      if (hph == 4'(CELL_W - 1)) begin
        hph <= '0;
        col <= col + 1'b1;
      end else begin
        hph <= hph + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vc <= '0; row <= '0; vph <= '0;
    end else if (h_last) begin
      if (v_last) begin
        vc <= '0; row <= '0; vph <= '0;
      end else begin
        vc <= vc + 1'b1;
        if (vph == 4'(CELL_H - 1)) begin
          vph <= '0;
          row <= row + 1'b1;
        end else begin
          vph <= vph + 1'b1;
        end
      end
    end
  end

  // blink phase
  logic [BW-1:0] frm;
  logic          blink_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm <= '0;
      blink_on <= 1'b1;
    end else if (h_last && v_last) begin
      if (int'(frm) == BLINK_FRAMES - 1) begin
        frm <= '0;
        blink_on <= ~blink_on;
      end else begin
        frm <= frm + 1'b1;
      end
    end
  end

  logic in_txt, cur_hit, hs_act, vs_act;

  assign in_txt  = (int'(hc) < TXT_W) && (int'(vc) < TXT_H);
  assign cur_hit = cur_en_i && blink_on && (row == VW'(cur_row_i)) && (col == HW'(cur_col_i));
  assign hs_act  = (int'(hc) >= HS_BEG) && (int'(hc) < HS_END);
  assign vs_act  = (int'(vc) >= VS_BEG) && (int'(vc) < VS_END);

  assign mem_addr_o = in_txt ? (AW'(row) * AW'(COLS) + AW'(col)) : '0;

  // stage 1: buffer data in flight
  logic       s1_txt, s1_ld, s1_cur, s1_hs, s1_vs;
  logic [3:0] s1_vph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_txt <= 1'b0; s1_ld <= 1'b0; s1_cur <= 1'b0;
      s1_hs  <= 1'b0; s1_vs <= 1'b0; s1_vph <= '0;
    end else begin
      s1_txt <= in_txt;
      s1_ld  <= in_txt && (hph == '0);
      s1_cur <= cur_hit;
      s1_hs  <= hs_act;
      s1_vs  <= vs_act;
      s1_vph <= vph;
    end
  end

  // stage 2: glyph lookup into the shift register
  logic [10:0] gidx;
  logic [8:0]  glyph, shreg;
  logic        s2_inv, s2_txt, s2_hs, s2_vs;

  assign gidx  = 11'(mem_data_i[6:0]) * 11'(CELL_H) + 11'(s1_vph);
  assign glyph = rom[gidx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg <= '0; s2_inv <= 1'b0;
      s2_txt <= 1'b0; s2_hs <= 1'b0; s2_vs <= 1'b0;
    end else begin
      if (s1_ld) begin
        shreg  <= glyph;
        s2_inv <= mem_data_i[7] ^ s1_cur;
      end else begin
        shreg  <= {shreg[7:0], 1'b0};
      end
      s2_txt <= s1_txt;
      s2_hs  <= s1_hs;
      s2_vs  <= s1_vs;
    end
  end

  // registered outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_o   <= 1'b0;
      hsync_o <= 1'b1;
      vsync_o <= 1'b0;
    end else begin
      vid_o   <= s2_txt && (shreg[8] ^ s2_inv);
      hsync_o <= ~s2_hs;
      vsync_o <= s2_vs;
    end
  end
endmodule

// File: rtl/txtvga_render_chk.sv
module txtvga_render_chk #(
  parameter int CELLS = 1920,
  parameter int AW    = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          vid_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [3:0]    hph
);
  // R7
  hblank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> !vid_o);

  // R7
  vblank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> !vid_o);

  // R2
  hsync_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_o) |=> !hsync_o);

  // R3
  vsync_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |=> vsync_o);

  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hph != 4'd0) |-> $stable(mem_addr_o));

  // R4
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(mem_addr_o) < CELLS);
endmodule

bind txtvga_render txtvga_render_chk #(.CELLS(COLS * ROWS), .AW(AW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .vid_o      (vid_o),
  .mem_addr_o (mem_addr_o),
  .hph        (hph)
);

// File: tb/txtvga_render_tb_top.sv
module txtvga_render_tb_top;
  localparam int COLS = 4, ROWS = 2;
  localparam int HA = 40, HFP = 4, HSY = 6, HBP = 6;
  localparam int VA = 20, VFP = 2, VSY = 2, VBP = 2;
  localparam int BLINK = 2;
  localparam int HT = HA + HFP + HSY + HBP;
  localparam int VT = VA + VFP + VSY + VBP;
  localparam int FT = HT * VT;
  localparam int AW = $clog2(COLS * ROWS);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cur_en = 1'b0;
  logic [RW-1:0] cur_row = '0;
  logic [CW-1:0] cur_col = '0;
  logic [AW-1:0] mem_addr;
  logic [7:0] rdata = 8'd0;
  logic hsync, vsync, vid;
  logic [7:0] mem [COLS*ROWS];

  int checks = 0;
  int errs = 0;
  int k = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) rdata <= mem[mem_addr];

  txtvga_render #(
    .COLS(COLS), .ROWS(ROWS),
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP),
    .BLINK_FRAMES(BLINK)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cur_en_i(cur_en),
    .cur_row_i(cur_row), .cur_col_i(cur_col),
    .mem_addr_o(mem_addr), .mem_data_i(rdata),
    .hsync_o(hsync), .vsync_o(vsync), .vid_o(vid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, k);
    end
  endtask

  task automatic check_cycle();
    int n, x, y, f, fx, fy, ea;
    int c, r, ph, rw, cl, pat, code, inv, ev;
    bit curcell, vis;
    string tag;
    n = k - 3;
    if (n < 0) begin
      chk("R1", "vid before first pixel", int'(vid), 0);
      chk("R1", "hsync before first pixel", int'(hsync), 1);
      chk("R1", "vsync before first pixel", int'(vsync), 0);
    end else begin
      x = n % HT;
      y = (n / HT) % VT;
      f = n / FT;
      chk("R2", "hsync", int'(hsync), (x >= HA + HFP && x < HA + HFP + HSY) ? 0 : 1);
      chk("R3", "vsync", int'(vsync), (y >= VA + VFP && y < VA + VFP + VSY) ? 1 : 0);
      if (x < COLS * 9 && y < ROWS * 9) begin
        cl = x / 9; ph = x % 9; rw = y / 9; r = y % 9;
        code = int'(mem[rw * COLS + cl]);
        c = code % 128;
        pat = (r < 8) ? (((c ^ r) & 127) << 1) : 0;
        vis = ((f / BLINK) % 2) == 0;
        curcell = (rw == int'(cur_row)) && (cl == int'(cur_col));
        inv = ((code >> 7) & 1) ^ ((cur_en && curcell && vis) ? 1 : 0);
        ev = ((pat >> (8 - ph)) & 1) ^ inv;
        if (curcell && !cur_en) tag = "R10";
        else if (curcell && vis) tag = "R8";
        else if (curcell) tag = "R9";
        else if (code >= 128) tag = "R6";
        else tag = "R5";
        chk(tag, "pixel", int'(vid), ev);
      end else begin
        chk("R7", "pixel outside text", int'(vid), 0);
      end
    end
    fx = k % HT;
    fy = (k / HT) % VT;
    ea = (fx < COLS * 9 && fy < ROWS * 9) ? (fy / 9) * COLS + fx / 9 : 0;
    chk("R4", "fetch address", int'(mem_addr), ea);
  endtask

  task automatic run_frames(input int nf);
    for (int i = 0; i < nf * FT; i++) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      check_cycle();
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < COLS * ROWS; i++) mem[i] = 8'((i * 37 + 5) & 127);
    repeat (3) @(negedge clk);
    chk("R1", "vid in reset", int'(vid), 0);
    chk("R1", "hsync in reset", int'(hsync), 1);
    chk("R1", "vsync in reset", int'(vsync), 0);
    chk("R1", "address in reset", int'(mem_addr), 0);
    rst_n = 1'b1;
    k = 0;
  endtask

  task automatic t_plain();
    run_frames(1);
  endtask

  task automatic t_reverse();
    for (int i = 0; i < COLS * ROWS; i++)
      mem[i] = 8'(((i * 11 + 64) & 127) | ((i % 2 == 1) ? 128 : 0));
    run_frames(1);
  endtask

  task automatic t_cursor_blink();
    cur_en = 1'b1;
    cur_row = RW'(1);
    cur_col = CW'(2);
    run_frames(4);
  endtask

  task automatic t_cursor_corner_reversed();
    mem[COLS * ROWS - 1] = 8'h80 | 8'h2A;
    cur_row = RW'(ROWS - 1);
    cur_col = CW'(COLS - 1);
    run_frames(4);
  endtask

  task automatic t_cursor_disabled();
    cur_en = 1'b0;
    cur_row = RW'(0);
    cur_col = CW'(0);
    run_frames(3);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_reverse();
    t_cursor_blink();
    t_cursor_corner_reversed();
    t_cursor_disabled();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule